// File: doc/BRIEF.md
# Dual-Buffer Sequential Address Pointer

This block generates the word address for the clocked side of a two-port buffer memory of 2^AW words (8K words at the default width). The pointer steps through memory one word per enabled clock edge. It can be loaded from the port's data bus, or set to the start of one of two buffer regions. Each region has a start and an end address, plus a two-bit policy that says what happens when the pointer arrives at its end. The policy can send the pointer to the other region, halt it, let it run on with a flag, or let it run on silently.

A separate command block owns the region registers and their reset defaults: region 1 from 0 to 4095, region 2 from 4096 to 8191, both in chaining mode. It presents them to this block as plain inputs, together with a one-cycle release pulse and per-region flag-clear pulses. The memory array and the data path sit outside. No stream passes through the block: every input is sampled on the clock edge, every output comes from a register, and there is no valid/ready handshake, so no back-pressure rules apply.

Top module: `seq_addr_pointer`

## Requirements
- R1: The pointer increases by exactly one on a rising edge where `cnt_en_n` is low and no load, start strobe, halt or region-end action applies. Where `cnt_en_n` is high and no load or strobe acts, the pointer does not move.
- R2: An edge with `load_n` low stores `ld_data` and leaves the pointer unchanged. The pointer takes the stored value on the following edge. `cnt_en_n` has no effect on either of those two edges.
- R3: An edge with `strt1_n` low copies `start1` into the pointer, and one with `strt2_n` low copies `start2` (`strt1_n` wins if both are low). Counting resumes on the very next edge.
- R4: Mode 00 (chaining): an advance that lands on a region's end address sets that region's flag on the same edge. The next advance from that address goes to the start of the other region.
- R5: When both ends are equal and both regions are chaining, both flags set on the same edge, and the next advance goes to `start1`.
- R6: Mode 01 (stop): the flag sets on arrival at the end address. On the following edge the pointer halts: at end+1 if `cnt_en_n` is low, at end otherwise. `wr_inhibit` is high and the pointer holds for as long as the halt lasts.
- R7: A `release_stop` pulse sampled while halted arms a release. On the next edge, if `cnt_en_n` is low the pointer goes to end+2 and `wr_inhibit` drops. If `cnt_en_n` is high, the release is dropped and the halt stays. A pointer load or a start strobe also ends a halt.
- R8: Mode 10 (linear): the flag sets at the end address and counting runs on past it. In mode 10 and mode 11 the pointer wraps from 2^AW-1 to 0.
- R9: Mode 11 (mask): counting runs past the end address and the region's `eob_n` bit stays high, but its `eob_stat` bit is still set.
- R10: The flags are sticky. `eob_n[0]`/`eob_stat[0]` belong to region 1 and bit 1 to region 2. A bit clears only through reset or a `clr_flag` pulse on that bit. A set on the same edge wins over a clear.
- R11: While `rst_n` is low, without waiting for a clock, the pointer is 0, `eob_n` is 11, `eob_stat` is 00, and `wr_inhibit` is low.
- R12: A start strobe must not be low on a load edge or on the edge after it (a checker flags it, and the load wins). A strobe on the edge right after the pointer has taken a loaded value is obeyed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| load_n | input | 1 | Pointer load strobe, active low (delayed by one edge) |
| ld_data | input | AW | Address captured on a load edge |
| strt1_n | input | 1 | Jump to start of region 1, active low |
| strt2_n | input | 1 | Jump to start of region 2, active low |
| start1 | input | AW | Region 1 start address |
| end1 | input | AW | Region 1 end address |
| start2 | input | AW | Region 2 start address |
| end2 | input | AW | Region 2 end address |
| mode1 | input | 2 | Region 1 end policy (00 chain, 01 stop, 10 linear, 11 mask) |
| mode2 | input | 2 | Region 2 end policy, same encoding |
| release_stop | input | 1 | One-cycle pulse that releases a halted pointer |
| clr_flag | input | 2 | One-cycle per-region flag clear, bit 0 for region 1 |
| ptr | output | AW | Current address pointer |
| wr_inhibit | output | 1 | High while the pointer is halted in stop mode |
| eob_n | output | 2 | End-of-region flags, active low, sticky |
| eob_stat | output | 2 | End-of-region status, active high, set in every mode |

## Verification
Every output comes straight from a register, so a wrong internal state shows on the ports at the first edge where it matters. A stuck load-pending bit freezes or misplaces `ptr` one edge after the load. A bad halt or arming bit shows as `wr_inhibit` out of step, or as a pointer that moves while it should hold. A wrong chain decision shows as a jump target on the edge after the end address. A flag register that fails to stick or to clear shows on `eob_n`/`eob_stat` on the very next edge. The bench therefore compares all four outputs against a behavioural model after every edge. This catches a divergence within one cycle of its cause, rather than only at the scenario checkpoints.

// File: rtl/sqp_pkg.sv
`timescale 1ns/1ps
package sqp_pkg;
  localparam int NBUF = 2;

  typedef enum logic [1:0] {
    FLOW_CHAIN  = 2'b00,
    FLOW_STOP   = 2'b01,
    FLOW_LINEAR = 2'b10,
    FLOW_MASK   = 2'b11
  } flow_e;
endpackage

// File: rtl/sqp_load_stage.sv
`timescale 1ns/1ps
// Holding register for the delayed pointer load.
module sqp_load_stage #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic [AW-1:0] ld_data,
  output logic          pend,
  output logic [AW-1:0] hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      hold <= '0;
    end else begin
      pend <= !load_n;
      if (!load_n) hold <= ld_data;
    end
  end
endmodule

// File: rtl/sqp_advance.sv
`timescale 1ns/1ps
// Next address for an ordinary advance, and which region ends it lands on.
module sqp_advance
  import sqp_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic [AW-1:0]            cur,
  input  logic [NBUF-1:0][AW-1:0]  starts,
  input  logic [NBUF-1:0][AW-1:0]  ends,
  input  logic [NBUF-1:0][1:0]     modes,
  output logic [AW-1:0]            nxt,
  output logic [NBUF-1:0]          hit
);
  logic [NBUF-1:0] chain_here;

  for (genvar g = 0; g < NBUF; g++) begin : g_end_cmp
    assign chain_here[g] = (cur == ends[g]) && (flow_e'(modes[g]) == FLOW_CHAIN);
    assign hit[g]        = (nxt == ends[g]);
  end

  // Leaving a chaining end goes to the other region; a shared end goes to region 1.
  always_comb begin
    if (chain_here[0] && chain_here[1]) nxt = starts[0];
    else if (chain_here[0])             nxt = starts[1];
    else if (chain_here[1])             nxt = starts[0];
    else                                nxt = cur + AW'(1);
  end
endmodule

// File: rtl/sqp_flag_bank.sv
`timescale 1ns/1ps
// Sticky end-of-region flags and status bits, one pair per region.
module sqp_flag_bank
  import sqp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] set_v,
  input  logic [NBUF-1:0] quiet_v,
  input  logic [NBUF-1:0] clr_v,
  output logic [NBUF-1:0] flag_n,
  output logic [NBUF-1:0] stat
);
  for (genvar g = 0; g < NBUF; g++) begin : g_flag
    logic shown_q;
    logic stat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shown_q <= 1'b0;
        stat_q  <= 1'b0;
      end else if (set_v[g]) begin
        stat_q <= 1'b1;
        if (!quiet_v[g]) shown_q <= 1'b1;
      end else if (clr_v[g]) begin
        stat_q  <= 1'b0;
        shown_q <= 1'b0;
      end
    end
    assign flag_n[g] = !shown_q;
    assign stat[g]   = stat_q;
  end
endmodule

// File: rtl/seq_addr_pointer.sv
`timescale 1ns/1ps
module seq_addr_pointer
  import sqp_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en_n,
  input  logic          load_n,
  input  logic [AW-1:0] ld_data,
  input  logic          strt1_n,
  input  logic          strt2_n,
  input  logic [AW-1:0] start1,
  input  logic [AW-1:0] end1,
  input  logic [AW-1:0] start2,
  input  logic [AW-1:0] end2,
  input  logic [1:0]    mode1,
  input  logic [1:0]    mode2,
  input  logic          release_stop,
  input  logic [1:0]    clr_flag,
  output logic [AW-1:0] ptr,
  output logic          wr_inhibit,
  output logic [1:0]    eob_n,
  output logic [1:0]    eob_stat
);
  logic [NBUF-1:0][AW-1:0] starts, ends;
  logic [NBUF-1:0][1:0]    modes;
  assign starts = {start2, start1};
  assign ends   = {end2, end1};
  assign modes  = {mode2, mode1};

  logic          pend_w;
  logic [AW-1:0] hold_w;
  logic [AW-1:0] nxt_w;
  logic [NBUF-1:0] hit_w, stop_hit, quiet_v, set_v;

  logic [AW-1:0] ptr_q, ptr_d, stop_end_q, stop_end_d;
  logic          halted_q, halted_d, armed_q, armed_d, rel_q, rel_d;
  logic          step_en;

  assign step_en = !cnt_en_n;

  sqp_load_stage #(.AW(AW)) u_load (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .ld_data(ld_data),
    .pend(pend_w), .hold(hold_w)
  );

  sqp_advance #(.AW(AW)) u_adv (
    .cur(ptr_q), .starts(starts), .ends(ends), .modes(modes),
    .nxt(nxt_w), .hit(hit_w)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_policy
    assign stop_hit[g] = hit_w[g] && (flow_e'(modes[g]) == FLOW_STOP);
    assign quiet_v[g]  = (flow_e'(modes[g]) == FLOW_MASK);
  end

  // Priority: pending load, load capture (freeze), start strobes, halt, arming, advance.
  always_comb begin
    ptr_d      = ptr_q;
    halted_d   = halted_q;
    armed_d    = armed_q;
    rel_d      = rel_q;
    stop_end_d = stop_end_q;
    set_v      = '0;
    if (pend_w) begin
      ptr_d    = hold_w;
      halted_d = 1'b0;
      armed_d  = 1'b0;
      rel_d    = 1'b0;
    end else if (!load_n) begin
      ptr_d = ptr_q;
    end else if (!strt1_n || !strt2_n) begin
      ptr_d    = !strt1_n ? start1 : start2;
      halted_d = 1'b0;
      armed_d  = 1'b0;
      rel_d    = 1'b0;
    end else if (halted_q) begin
      if (rel_q && step_en) begin
        ptr_d    = stop_end_q + AW'(2);
        halted_d = 1'b0;
        rel_d    = 1'b0;
      end else begin
        rel_d = release_stop;
      end
    end else if (armed_q) begin
      armed_d  = 1'b0;
      halted_d = 1'b1;
      if (step_en) ptr_d = ptr_q + AW'(1);
    end else if (step_en) begin
      ptr_d = nxt_w;
      set_v = hit_w;
      if (|stop_hit) begin
        armed_d    = 1'b1;
        stop_end_d = nxt_w;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      stop_end_q <= '0;
      halted_q   <= 1'b0;
      armed_q    <= 1'b0;
      rel_q      <= 1'b0;
    end else begin
      ptr_q      <= ptr_d;
      stop_end_q <= stop_end_d;
      halted_q   <= halted_d;
      armed_q    <= armed_d;
      rel_q      <= rel_d;
    end
  end

  sqp_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .quiet_v(quiet_v),
    .clr_v(clr_flag), .flag_n(eob_n), .stat(eob_stat)
  );

  assign ptr        = ptr_q;
  assign wr_inhibit = halted_q;
endmodule

// File: rtl/sqp_checker.sv
`timescale 1ns/1ps
module sqp_checker #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en_n,
  input logic          load_n,
  input logic [AW-1:0] ld_data,
  input logic          strt1_n,
  input logic          strt2_n,
  input logic [AW-1:0] end1,
  input logic [AW-1:0] end2,
  input logic [1:0]    clr_flag,
  input logic [AW-1:0] ptr,
  input logic          wr_inhibit,
  input logic [1:0]    eob_n,
  input logic [1:0]    eob_stat,
  input logic          pend,
  input logic          armed,
  input logic          rel
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_n && load_n && !pend && strt1_n && strt2_n && !wr_inhibit && !armed
     && ptr != end1 && ptr != end2) |=> ptr == $past(ptr) + AW'(1));

  // R1
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_n && load_n && !pend && strt1_n && strt2_n) |=> $stable(ptr));

  // R2
  load_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !pend) |=> $stable(ptr));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> ptr == $past(ld_data, 2));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inhibit && !rel && load_n && !pend && strt1_n && strt2_n)
      |=> ($stable(ptr) && wr_inhibit));

  // R10
  flag0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eob_n[0] && !clr_flag[0]) |=> !eob_n[0]);

  // R10
  flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eob_n[1] && !clr_flag[1]) |=> !eob_n[1]);

  // R9
  stat_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!eob_n[0] |-> eob_stat[0]) and (!eob_n[1] |-> eob_stat[1])));

  // R12
  strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strt1_n || !strt2_n) |-> (load_n && !pend));

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (ptr == '0 && eob_n == 2'b11 && eob_stat == 2'b00 && !wr_inhibit);
    end
  end
endmodule

bind seq_addr_pointer sqp_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .load_n(load_n), .ld_data(ld_data),
  .strt1_n(strt1_n), .strt2_n(strt2_n), .end1(end1), .end2(end2), .clr_flag(clr_flag),
  .ptr(ptr), .wr_inhibit(wr_inhibit), .eob_n(eob_n), .eob_stat(eob_stat),
  .pend(pend_w), .armed(armed_q), .rel(rel_q)
);

// File: tb/seq_addr_pointer_test.sv
`timescale 1ns/1ps
module seq_addr_pointer_test;
  localparam int AW = 13;
  localparam int SPAN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en_n = 1'b1, load_n = 1'b1, strt1_n = 1'b1, strt2_n = 1'b1;
  logic [AW-1:0] ld_data = '0;
  logic [AW-1:0] start1 = 13'd0, end1 = 13'd4095, start2 = 13'd4096, end2 = 13'd8191;
  logic [1:0] mode1 = 2'b00, mode2 = 2'b00;
  logic release_stop = 1'b0;
  logic [1:0] clr_flag = 2'b00;
  logic [AW-1:0] ptr;
  logic wr_inhibit;
  logic [1:0] eob_n, eob_stat;

  int checks = 0, fails = 0;
  string cur_req = "R11";
  bit done = 0;

  always #5 clk = ~clk;

  seq_addr_pointer #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .load_n(load_n), .ld_data(ld_data),
    .strt1_n(strt1_n), .strt2_n(strt2_n), .start1(start1), .end1(end1),
    .start2(start2), .end2(end2), .mode1(mode1), .mode2(mode2),
    .release_stop(release_stop), .clr_flag(clr_flag), .ptr(ptr),
    .wr_inhibit(wr_inhibit), .eob_n(eob_n), .eob_stat(eob_stat)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: pointer state held in plain integers.
  int m_ptr, m_hold, m_stopend;
  bit m_pend, m_halt, m_arm, m_rel;
  bit m_shown[2], m_stat[2];

  always @(posedge clk or negedge rst_n) begin : model
    int nxt;
    bit land[2];
    bit jump1, jump2;
    int ends_i[2], modes_i[2];
    if (!rst_n) begin
      m_ptr = 0; m_hold = 0; m_stopend = 0;
      m_pend = 0; m_halt = 0; m_arm = 0; m_rel = 0;
      m_shown = '{0, 0}; m_stat = '{0, 0};
    end else begin
      ends_i = '{int'(end1), int'(end2)};
      modes_i = '{int'(mode1), int'(mode2)};
      land = '{0, 0};
      if (m_pend) begin
        m_ptr = m_hold; m_halt = 0; m_arm = 0; m_rel = 0;
      end else if (!load_n) begin
        m_ptr = m_ptr;
      end else if (!strt1_n || !strt2_n) begin
        m_ptr = !strt1_n ? int'(start1) : int'(start2);
        m_halt = 0; m_arm = 0; m_rel = 0;
      end else if (m_halt) begin
        if (m_rel && !cnt_en_n) begin
          m_ptr = (m_stopend + 2) % SPAN; m_halt = 0; m_rel = 0;
        end else m_rel = release_stop;
      end else if (m_arm) begin
        m_arm = 0; m_halt = 1;
        if (!cnt_en_n) m_ptr = (m_ptr + 1) % SPAN;
      end else if (!cnt_en_n) begin
        jump1 = (m_ptr == ends_i[0]) && modes_i[0] == 0;
        jump2 = (m_ptr == ends_i[1]) && modes_i[1] == 0;
        if (jump1) nxt = jump2 ? int'(start1) : int'(start2);
        else if (jump2) nxt = int'(start1);
        else nxt = (m_ptr + 1) % SPAN;
        m_ptr = nxt;
        for (int b = 0; b < 2; b++) begin
          if (nxt == ends_i[b]) begin
            land[b] = 1;
            if (modes_i[b] == 1) begin m_arm = 1; m_stopend = nxt; end
          end
        end
      end
      for (int b = 0; b < 2; b++) begin
        if (land[b]) begin
          m_stat[b] = 1;
          if (modes_i[b] != 3) m_shown[b] = 1;
        end else if (clr_flag[b]) begin
          m_stat[b] = 0; m_shown[b] = 0;
        end
      end
      m_pend = !load_n;
      if (!load_n) m_hold = int'(ld_data);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "ptr vs model", int'(ptr), m_ptr);
      check(cur_req, "wr_inhibit vs model", int'(wr_inhibit), int'(m_halt));
      check(cur_req, "eob_n vs model", int'(eob_n), int'({!m_shown[1], !m_shown[0]}));
      check(cur_req, "eob_stat vs model", int'(eob_stat), int'({m_stat[1], m_stat[0]}));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    clr_flag = 2'b11; cyc(1); clr_flag = 2'b00;
  endtask

  task automatic do_load(input int val);
    ld_data = AW'(val); load_n = 1'b0; cyc(1); load_n = 1'b1; cyc(1);
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    cyc(3);
    cur_req = "R11";
    check("R11", "reset ptr", int'(ptr), 0);
    check("R11", "reset eob_n", int'(eob_n), 3);
    rst_n = 1'b1;
    cyc(1);

    cur_req = "R1";
    cnt_en_n = 1'b0; cyc(5);
    check("R1", "count five", int'(ptr), 5);
    cnt_en_n = 1'b1; cyc(3);
    check("R1", "count disabled hold", int'(ptr), 5);

    cur_req = "R2";
    cnt_en_n = 1'b0; ld_data = 13'd100; load_n = 1'b0; cyc(1);
    check("R2", "load edge freezes", int'(ptr), 5);
    load_n = 1'b1; cyc(1);
    check("R2", "load takes effect", int'(ptr), 100);
    cyc(1);
    check("R2", "count after load", int'(ptr), 101);
    cnt_en_n = 1'b1;

    cur_req = "R3";
    start1 = 13'd10; end1 = 13'd13; start2 = 13'd20; end2 = 13'd23;
    strt1_n = 1'b0; cyc(1); strt1_n = 1'b1;
    check("R3", "start1 strobe", int'(ptr), 10);
    strt2_n = 1'b0; cnt_en_n = 1'b0; cyc(1); strt2_n = 1'b1;
    check("R3", "start2 strobe", int'(ptr), 20);
    cyc(1);
    check("R3", "count right after strobe", int'(ptr), 21);

    cur_req = "R12";
    do_load(40);
    check("R12", "loaded before strobe", int'(ptr), 40);
    strt1_n = 1'b0; cyc(1); strt1_n = 1'b1;
    check("R12", "strobe after load obeyed", int'(ptr), 10);

    cur_req = "R4";
    cyc(3);
    check("R4", "reach end1", int'(ptr), 13);
    check("R4", "flag1 set with end", int'(eob_n), 2);
    cyc(1);
    check("R4", "chain to start2", int'(ptr), 20);
    cyc(3);
    check("R4", "both flags after end2", int'(eob_n), 0);
    cyc(1);
    check("R4", "chain to start1", int'(ptr), 10);
    cnt_en_n = 1'b1;

    cur_req = "R10";
    check("R10", "flags held", int'(eob_stat), 3);
    clr_flag = 2'b01; cyc(1); clr_flag = 2'b00;
    check("R10", "clear region 1 only", int'(eob_n), 1);
    check("R10", "status region 2 kept", int'(eob_stat), 2);
    clr_flag = 2'b10; cyc(1); clr_flag = 2'b00;
    check("R10", "clear region 2", int'(eob_n), 3);

    cur_req = "R5";
    end2 = 13'd13; cnt_en_n = 1'b0; cyc(3);
    check("R5", "equal ends both flags", int'(eob_n), 0);
    cyc(1);
    check("R5", "equal ends go start1", int'(ptr), 10);
    cnt_en_n = 1'b1; clear_flags(); end2 = 13'd23;

    cur_req = "R6";
    mode1 = 2'b01; cnt_en_n = 1'b0; cyc(3);
    check("R6", "stop end reached", int'(ptr), 13);
    check("R6", "no inhibit yet", int'(wr_inhibit), 0);
    cyc(1);
    check("R6", "halt at end+1", int'(ptr), 14);
    check("R6", "inhibit while halted", int'(wr_inhibit), 1);
    cyc(2);
    check("R6", "halted holds", int'(ptr), 14);
    cur_req = "R7";
    cnt_en_n = 1'b1; release_stop = 1'b1; cyc(1); release_stop = 1'b0;
    cnt_en_n = 1'b0; cyc(1);
    check("R7", "release to end+2", int'(ptr), 15);
    check("R7", "inhibit dropped", int'(wr_inhibit), 0);
    cnt_en_n = 1'b1;

    cur_req = "R6";
    strt1_n = 1'b0; cyc(1); strt1_n = 1'b1; clear_flags();
    cnt_en_n = 1'b0; cyc(3); cnt_en_n = 1'b1; cyc(1);
    check("R6", "halt at end without count", int'(ptr), 13);
    check("R6", "inhibit at end", int'(wr_inhibit), 1);
    cur_req = "R7";
    release_stop = 1'b1; cyc(1); release_stop = 1'b0; cyc(1);
    check("R7", "release lost without count", int'(wr_inhibit), 1);
    cnt_en_n = 1'b0; cyc(1);
    check("R7", "still halted", int'(ptr), 13);
    release_stop = 1'b1; cyc(1); release_stop = 1'b0; cyc(1);
    check("R7", "release from end to end+2", int'(ptr), 15);
    cnt_en_n = 1'b1;

    strt1_n = 1'b0; cyc(1); strt1_n = 1'b1; clear_flags();
    cnt_en_n = 1'b0; cyc(4);
    check("R7", "halted before load", int'(wr_inhibit), 1);
    do_load(50);
    check("R7", "load releases halt", int'(ptr), 50);
    check("R7", "load clears inhibit", int'(wr_inhibit), 0);
    cnt_en_n = 1'b1; clear_flags();

    cur_req = "R8";
    mode1 = 2'b10;
    strt1_n = 1'b0; cyc(1); strt1_n = 1'b1;
    cnt_en_n = 1'b0; cyc(3);
    check("R8", "linear flag", int'(eob_n), 2);
    cyc(1);
    check("R8", "linear runs past", int'(ptr), 14);
    cnt_en_n = 1'b1;
    do_load(8190);
    cnt_en_n = 1'b0; cyc(1);
    check("R8", "top address", int'(ptr), 8191);
    cyc(1);
    check("R8", "wrap to zero", int'(ptr), 0);
    cnt_en_n = 1'b1; clear_flags();

    cur_req = "R9";
    mode1 = 2'b11;
    strt1_n = 1'b0; cyc(1); strt1_n = 1'b1;
    cnt_en_n = 1'b0; cyc(3);
    check("R9", "mask flag stays high", int'(eob_n), 3);
    check("R9", "mask status set", int'(eob_stat), 1);
    cyc(1);
    check("R9", "mask runs past", int'(ptr), 14);

    cur_req = "R11";
    cyc(1);
    #2 rst_n = 1'b0;
    #1;
    check("R11", "async reset ptr", int'(ptr), 0);
    check("R11", "async reset status", int'(eob_stat), 0);
    check("R11", "async reset flags", int'(eob_n), 3);
    cnt_en_n = 1'b1;
    cyc(2);
    rst_n = 1'b1;
    cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule